// File: doc/BRIEF.md
# Power Register Command Executor

This block runs on the controller side of a mailbox. It serves commands that read or write a bank of 8-bit power-management registers, each reached by a 16-bit address. A doorbell carries a message type, a sub-command id and a size field. When the doorbell comes, the engine takes a snapshot of the 16-byte write buffer. It checks the command, then runs a multi-register read, a multi-register write or a masked read-modify-write on its internal register file, one register per clock.

Read results go back one byte at a time through a read-buffer write strobe. When all work is done, the engine raises a one-cycle completion strobe, together with an error flag and an error code. The mailbox registers sit outside the block, and so does any real power hardware. A command can only see the register file through read commands.

Top module: `pwr_cmd_engine`

## Requirements
- R1: Only message type 0xFF is served; any other type completes with error code 1. With type 0xFF, sub-id 0 selects write, 1 selects read and 2 selects read-modify-write; any other sub-id completes with error code 2. Checks run in this order: type, then sub-id, then length, then address range. Only the first failing check reports its code.
- R2: The write buffer byte n is `wbuf[8n+7:8n]`. Register address i (i from 0) sits in byte pair 2i (low byte) and 2i+1 (high byte).
- R3: For a write, size must equal 3×count. Data byte i sits at buffer byte 2×count+i. The registers are written in list order, so a repeated address keeps the last value.
- R4: For a read, size must equal 2×count. The value at address i is placed in read-buffer byte i for i from 0 to count−1, and no other read-buffer byte is written.
- R5: A read-modify-write needs size 4 and uses one address. Byte 2 holds the value and byte 3 the mask. The register becomes (old AND NOT mask) OR (value AND mask).
- R6: A count of zero, a count above 5, or a size that fits no count completes with error code 3 and leaves the register file unchanged.
- R7: An address of NREG (64) or above in a command that is otherwise valid completes with error code 4. No register of that command is written and no read-buffer byte is written.
- R8: `done` is a one-cycle pulse. Count the doorbell clock edge as edge 0. An accepted command raises `done` in the cycle after edge count+1; a rejected command raises it in the cycle after edge 1.
- R9: `err` and `err_code` are valid while `done` is high, with code 0 and `err` low on success. They hold their value until the next doorbell is accepted.
- R10: `busy` is high from the cycle after an accepted doorbell until the cycle after `done`. A doorbell that arrives while `busy` is high is ignored.
- R11: After reset, every register reads 0 and `busy`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| db_valid | input | 1 | Doorbell: a command is present this cycle |
| db_type | input | 8 | Message type |
| db_sub | input | 4 | Sub-command id |
| db_size | input | 8 | Size field |
| wbuf | input | 8*BUFB | Write buffer contents, byte n at bits 8n+7:8n |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion strobe |
| err | output | 1 | Last command failed |
| err_code | output | 8 | Failure reason (0 ok, 1 type, 2 sub-id, 3 length, 4 range) |
| rb_we | output | 1 | Read-buffer byte write strobe |
| rb_idx | output | $clog2(BUFB) | Read-buffer byte index |
| rb_byte | output | 8 | Read-buffer byte value |

## Verification
The assertions assume three things about the mailbox. It presents `wbuf` and the command fields stable on the doorbell cycle. It treats `done` as the only end-of-command event. It never relies on read-buffer writes outside a busy period.

The stimulus keeps to these rules. It drives all fields and the doorbell on the falling edge and pulses `db_valid` for one cycle. It waits for `done` before the next command. The one exception is a deliberate doorbell sent during a busy period, which the design must ignore.

// File: rtl/pwr_cmd_pkg.sv
// Shared constants and types for the power register command executor.
package pwr_cmd_pkg;
    localparam logic [7:0] MSG_PWR   = 8'hFF;
    localparam logic [7:0] CODE_OK   = 8'd0;
    localparam logic [7:0] CODE_TYPE = 8'd1;
    localparam logic [7:0] CODE_SUB  = 8'd2;
    localparam logic [7:0] CODE_LEN  = 8'd3;
    localparam logic [7:0] CODE_RNG  = 8'd4;

    typedef enum logic [1:0] {
        OP_WR  = 2'd0,
        OP_RD  = 2'd1,
        OP_RMW = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_EXEC  = 2'd2,
        ST_FIN   = 2'd3
    } state_e;
endpackage

// File: rtl/cmd_decode.sv
// cmd_decode: turns type, sub-id and size into an operation, a register
// count and an error code. Purely combinational.
// Assumes: inputs are the captured command fields, stable during the check state.
module cmd_decode
    import pwr_cmd_pkg::*;
#(
    parameter int MAXN = 5,
    parameter int CW   = 3
) (
    input  logic [7:0]    msg_type,
    input  logic [3:0]    sub_id,
    input  logic [7:0]    size,
    output op_e           op,
    output logic [CW-1:0] cnt,
    output logic [7:0]    code
);
    logic [7:0] third;
    logic [7:0] half;

    assign third = size / 8'd3;
    assign half  = {1'b0, size[7:1]};

    // Validate the command and derive the register count.
    always_comb begin
        op   = OP_WR;
        cnt  = '0;
        code = CODE_OK;
        if (msg_type != MSG_PWR) begin
            code = CODE_TYPE;
        end else begin
            case (sub_id)
                4'd0: begin
                    op  = OP_WR;
                    cnt = third[CW-1:0];
                    if ((third * 8'd3 != size) || third == 8'd0 || third > 8'(MAXN))
                        code = CODE_LEN;
                end
                4'd1: begin
                    op  = OP_RD;
                    cnt = half[CW-1:0];
                    if (size[0] || half == 8'd0 || half > 8'(MAXN))
                        code = CODE_LEN;
                end
                4'd2: begin
                    op  = OP_RMW;
                    cnt = CW'(1);
                    if (size != 8'd4)
                        code = CODE_LEN;
                end
                default: code = CODE_SUB;
            endcase
        end
    end
endmodule

// File: rtl/addr_screen.sv
// addr_screen: flags a command if any of its first cnt addresses lies
// outside the implemented register range.
// Assumes: cnt <= MAXN; unused slots are ignored.
module addr_screen #(
    parameter int MAXN = 5,
    parameter int CW   = 3,
    parameter int NREG = 64
) (
    input  logic [MAXN-1:0][15:0] slot_addr,
    input  logic [CW-1:0]         cnt,
    output logic                  any_bad
);
    logic [MAXN-1:0] bad;

    // One comparator per address slot.
    for (genvar g = 0; g < MAXN; g++) begin : g_slot
        assign bad[g] = (CW'(g) < cnt) && (slot_addr[g] >= 16'(NREG));
    end

    assign any_bad = |bad;
endmodule

// File: rtl/reg_bank.sv
// reg_bank: NREG x 8-bit register file with one asynchronous read port
// and one synchronous write port. Resets every entry to zero.
// Assumes: addresses are already range-checked.
module reg_bank #(
    parameter int NREG = 64,
    parameter int AW   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata
);
    logic [7:0] mem [NREG];

    assign rdata = mem[raddr];

    // Clear on reset, otherwise store one byte when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/pwr_cmd_engine.sv
// pwr_cmd_engine: mailbox command executor for a bank of 8-bit power
// registers. It captures a command on the doorbell, validates it for one
// cycle, touches one register per cycle, then pulses done.
// Assumes: wbuf and the command fields are valid during the doorbell cycle.
module pwr_cmd_engine
    import pwr_cmd_pkg::*;
#(
    parameter int NREG = 64,
    parameter int MAXN = 5,
    parameter int BUFB = 16,
    localparam int BW  = $clog2(BUFB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              db_valid,
    input  logic [7:0]        db_type,
    input  logic [3:0]        db_sub,
    input  logic [7:0]        db_size,
    input  logic [8*BUFB-1:0] wbuf,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [7:0]        err_code,
    output logic              rb_we,
    output logic [BW-1:0]     rb_idx,
    output logic [7:0]        rb_byte
);
    localparam int AW = $clog2(NREG);
    localparam int CW = $clog2(MAXN + 1);

    state_e                 state;
    logic [7:0]             cap [BUFB];
    logic [7:0]             c_type;
    logic [3:0]             c_sub;
    logic [7:0]             c_size;
    logic [CW-1:0]          idx;
    logic [MAXN-1:0][15:0]  slot_addr;
    op_e                    op;
    logic [CW-1:0]          cnt;
    logic [7:0]             dec_code;
    logic                   range_bad;
    logic                   accept;
    logic                   last;
    logic [AW-1:0]          cur_addr;
    logic [7:0]             rdata;
    logic                   bank_we;
    logic [7:0]             wdata;
    logic [BW-1:0]          dsel;

    assign accept = db_valid && (state == ST_IDLE);
    assign busy   = (state != ST_IDLE);
    assign done   = (state == ST_FIN);

    // Address list: pair 2g (low) and 2g+1 (high) of the captured buffer.
    for (genvar g = 0; g < MAXN; g++) begin : g_addr
        assign slot_addr[g] = {cap[2*g+1], cap[2*g]};
    end

    cmd_decode #(.MAXN(MAXN), .CW(CW)) u_dec (
        .msg_type (c_type),
        .sub_id   (c_sub),
        .size     (c_size),
        .op       (op),
        .cnt      (cnt),
        .code     (dec_code)
    );

    addr_screen #(.MAXN(MAXN), .CW(CW), .NREG(NREG)) u_scr (
        .slot_addr (slot_addr),
        .cnt       (cnt),
        .any_bad   (range_bad)
    );

    assign cur_addr = slot_addr[idx][AW-1:0];
    assign last     = (idx + CW'(1)) == cnt;
    assign dsel     = BW'({cnt, 1'b0}) + BW'(idx);

    // Per-cycle access: choose the write value and the read-buffer strobe.
    always_comb begin
        bank_we = 1'b0;
        wdata   = cap[dsel];
        rb_we   = 1'b0;
        rb_idx  = BW'(idx);
        rb_byte = rdata;
        if (state == ST_EXEC) begin
            case (op)
                OP_RD:   rb_we = 1'b1;
                OP_RMW: begin
                    bank_we = 1'b1;
                    wdata   = (rdata & ~cap[3]) | (cap[2] & cap[3]);
                end
                default: bank_we = 1'b1;
            endcase
        end
    end

    reg_bank #(.NREG(NREG), .AW(AW)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .raddr (cur_addr),
        .rdata (rdata),
        .we    (bank_we),
        .waddr (cur_addr),
        .wdata (wdata)
    );

    // Capture the command fields and buffer snapshot on an accepted doorbell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_type <= '0;
            c_sub  <= '0;
            c_size <= '0;
            for (int i = 0; i < BUFB; i++) cap[i] <= '0;
        end else if (accept) begin
            c_type <= db_type;
            c_sub  <= db_sub;
            c_size <= db_size;
            for (int i = 0; i < BUFB; i++) cap[i] <= wbuf[8*i +: 8];
        end
    end

    // Sequencer: idle, check, one register per cycle, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            err      <= 1'b0;
            err_code <= CODE_OK;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    state    <= ST_CHECK;
                    err      <= 1'b0;
                    err_code <= CODE_OK;
                end
                ST_CHECK: begin
                    idx <= '0;
                    if (dec_code != CODE_OK) begin
                        err      <= 1'b1;
                        err_code <= dec_code;
                        state    <= ST_FIN;
                    end else if (range_bad) begin
                        err      <= 1'b1;
                        err_code <= CODE_RNG;
                        state    <= ST_FIN;
                    end else begin
                        state <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    idx <= idx + CW'(1);
                    if (last) state <= ST_FIN;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pwr_cmd_engine_chk.sv
// pwr_cmd_engine_chk: protocol checks on the executor's ports and its
// register-file write strobe. Bound into every pwr_cmd_engine instance.
module pwr_cmd_engine_chk #(
    parameter int MAXN = 5,
    parameter int BW   = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          db_valid,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic [7:0]    err_code,
    input logic          rb_we,
    input logic [BW-1:0] rb_idx,
    input logic          bank_we
);
    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: error flag and code agree at completion
    a_r9_code_match: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err == (err_code != 8'd0)));
    // R10: an accepted doorbell makes the engine busy
    a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (db_valid && !busy) |=> busy);
    // R10: engine returns to idle after completion
    a_r10_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R4: read-buffer writes stay within the first MAXN bytes and inside a command
    a_r4_rb_range: assert property (@(posedge clk) disable iff (!rst_n)
        rb_we |-> (busy && !done && (rb_idx < BW'(MAXN))));
    // R7: register writes only during execution, never with a failing completion
    a_r7_write_inside: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |-> (busy && !done && !rb_we));
endmodule

bind pwr_cmd_engine pwr_cmd_engine_chk #(.MAXN(MAXN), .BW(BW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .db_valid (db_valid),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .err_code (err_code),
    .rb_we    (rb_we),
    .rb_idx   (rb_idx),
    .bank_we  (bank_we)
);

// File: tb/pwr_cmd_engine_tb.sv
module pwr_cmd_engine_tb;
    localparam int NREG = 64;
    localparam int MAXN = 5;
    localparam int BUFB = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic db_valid = 1'b0;
    logic [7:0] db_type = '0;
    logic [3:0] db_sub = '0;
    logic [7:0] db_size = '0;
    logic [8*BUFB-1:0] wbuf = '0;
    logic busy, done, err, rb_we;
    logic [7:0] err_code, rb_byte;
    logic [3:0] rb_idx;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] refm [NREG];
    logic [7:0] rbm [BUFB];
    logic [7:0] wb [BUFB];

    always #2 clk = ~clk;

    pwr_cmd_engine #(.NREG(NREG), .MAXN(MAXN), .BUFB(BUFB)) u_dut (
        .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .db_type(db_type),
        .db_sub(db_sub), .db_size(db_size), .wbuf(wbuf), .busy(busy),
        .done(done), .err(err), .err_code(err_code), .rb_we(rb_we),
        .rb_idx(rb_idx), .rb_byte(rb_byte));

    // Model of the read buffer, fed by the strobe.
    always @(posedge clk) if (rb_we) rbm[rb_idx] <= rb_byte;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected error code, by R1/R6/R7 priority.
    function automatic int f_code(input int ty, input int sb, input int sz, output int cnt);
        cnt = 0;
        if (ty != 8'hFF) return 1;
        if (sb == 0) begin
            cnt = sz / 3;
            if (sz % 3 != 0 || cnt < 1 || cnt > MAXN) return 3;
        end else if (sb == 1) begin
            cnt = sz / 2;
            if (sz % 2 != 0 || cnt < 1 || cnt > MAXN) return 3;
        end else if (sb == 2) begin
            cnt = 1;
            if (sz != 4) return 3;
        end else return 2;
        for (int i = 0; i < cnt; i++)
            if ({wb[2*i+1], wb[2*i]} >= NREG) return 4;
        return 0;
    endfunction

    // Issue one command from wb[], check timing, status, read data and update the model.
    task automatic issue(input int ty, input int sb, input int sz, input bit inject);
        int cnt, code, lat, ea;
        logic [7:0] e8;
        code = f_code(ty, sb, sz, cnt);
        for (int i = 0; i < BUFB; i++) begin
            wbuf[8*i +: 8] = wb[i];
            rbm[i] = 8'hEE;
        end
        db_type = 8'(ty); db_sub = 4'(sb); db_size = 8'(sz);
        db_valid = 1'b1;
        @(negedge clk);
        db_valid = 1'b0;
        lat = 1;
        check(busy === 1'b1, "R10 busy after doorbell", busy, 1);
        while (done !== 1'b1 && lat < 40) begin
            if (inject && lat == 1) begin
                db_type = 8'hFF; db_sub = 4'd0; db_size = 8'd3;
                wbuf = '0; wbuf[7:0] = 8'd7; wbuf[23:16] = 8'h5A;
                db_valid = 1'b1;
            end else db_valid = 1'b0;
            @(negedge clk);
            lat++;
        end
        db_valid = 1'b0;
        check(lat == ((code != 0) ? 2 : cnt + 2), "R8 done latency", lat, (code != 0) ? 2 : cnt + 2);
        check(err_code == 8'(code), "R1/R6/R7 err_code (R9)", err_code, code);
        check(err == (code != 0), "R9 err flag", err, code != 0);
        if (code == 0 && sb == 1) begin
            for (int i = 0; i < BUFB; i++) begin
                ea = {wb[2*i+1], wb[2*i]};
                e8 = (i < cnt) ? refm[ea % NREG] : 8'hEE;
                check(rbm[i] == e8, "R4 read buffer byte", rbm[i], e8);
            end
        end else begin
            for (int i = 0; i < BUFB; i++)
                check(rbm[i] == 8'hEE, "R7 no read-buffer write", rbm[i], 8'hEE);
        end
        if (code == 0 && sb == 0)
            for (int i = 0; i < cnt; i++) refm[{wb[2*i+1], wb[2*i]}] = wb[2*cnt+i];
        if (code == 0 && sb == 2) begin
            ea = {wb[1], wb[0]};
            refm[ea] = (refm[ea] & ~wb[3]) | (wb[2] & wb[3]);
        end
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R8 done single pulse", done, 0);
        check(err_code == 8'(code), "R9 code held", err_code, code);
        if (inject) begin
            repeat (4) begin
                @(negedge clk);
                check(done === 1'b0, "R10 busy doorbell ignored", done, 0);
            end
        end
    endtask

    task automatic clear_wb();
        for (int i = 0; i < BUFB; i++) wb[i] = 8'($urandom);
    endtask

    task automatic put_addr(input int i, input int a);
        wb[2*i] = 8'(a); wb[2*i+1] = 8'(a >> 8);
    endtask

    // Read back the whole register file in groups of five.
    task automatic sweep();
        for (int b = 0; b < NREG; b += 5) begin
            int n;
            n = (NREG - b < 5) ? NREG - b : 5;
            clear_wb();
            for (int i = 0; i < n; i++) put_addr(i, b + i);
            issue(8'hFF, 1, 2*n, 1'b0);
        end
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < NREG; i++) refm[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R11 reset outputs", {busy, done, err}, 0);
        sweep();  // R11: all registers zero

        // R3: five-register write, then R4 read back in reversed order (R2 byte order)
        clear_wb();
        for (int i = 0; i < 5; i++) begin put_addr(i, 10 + i); wb[10+i] = 8'(8'hA0 + i); end
        issue(8'hFF, 0, 15, 1'b0);
        clear_wb();
        for (int i = 0; i < 5; i++) put_addr(i, 14 - i);
        issue(8'hFF, 1, 10, 1'b0);
        // R3: duplicate address, last value wins
        clear_wb(); put_addr(0, 20); put_addr(1, 20); wb[4] = 8'h11; wb[5] = 8'h22;
        issue(8'hFF, 0, 6, 1'b0);
        // R5: masked update
        clear_wb(); put_addr(0, 20); wb[2] = 8'hF0; wb[3] = 8'h3C;
        issue(8'hFF, 2, 4, 1'b0);
        // R1: bad type and bad sub-id
        clear_wb(); put_addr(0, 1);
        issue(8'h7F, 0, 3, 1'b0);
        issue(8'hFF, 3, 3, 1'b0);
        // R6: count 0, count 6, size not a multiple, rmw size wrong
        issue(8'hFF, 1, 0, 1'b0);
        issue(8'hFF, 1, 12, 1'b0);
        issue(8'hFF, 0, 7, 1'b0);
        issue(8'hFF, 2, 3, 1'b0);
        // R7: last address out of range, nothing written
        clear_wb(); put_addr(0, 30); put_addr(1, 16'h0140); wb[4] = 8'h99; wb[5] = 8'h98;
        issue(8'hFF, 0, 6, 1'b0);
        clear_wb(); put_addr(0, 64);
        issue(8'hFF, 1, 2, 1'b0);
        // R10: doorbell while busy ignored
        clear_wb(); for (int i = 0; i < 5; i++) put_addr(i, i);
        issue(8'hFF, 1, 10, 1'b1);

        // Constrained random mix
        for (int t = 0; t < 150; t++) begin
            int sb, cnt, sz, ty;
            clear_wb();
            sb = $urandom_range(0, 9) < 9 ? $urandom_range(0, 2) : $urandom_range(3, 15);
            ty = $urandom_range(0, 19) == 0 ? 8'h3C : 8'hFF;
            cnt = (sb == 2) ? 1 : $urandom_range(1, 5);
            for (int i = 0; i < cnt; i++)
                put_addr(i, ($urandom_range(0, 24) == 0) ? $urandom_range(64, 65535) : $urandom_range(0, NREG - 1));
            sz = (sb == 0) ? 3 * cnt : (sb == 1) ? 2 * cnt : 4;
            if ($urandom_range(0, 14) == 0) sz = $urandom_range(0, 20);
            issue(ty, sb, sz, 1'b0);
        end
        sweep();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule